// File: doc/BRIEF.md
# Compound Prediction Pixel Blender

This block merges two planes of signed 16-bit intermediate prediction samples into one block of unsigned 8-bit pixels. It has three blend modes. The plain mode takes the rounded mean of the two planes. The weighted mode uses one scalar weight for the whole block. The masked mode applies a separate 6-bit-range mask value at every pixel. Every mode rounds exactly as the codec's fixed-point compound formulas require, and the result is then clamped to 0..255.

A one-cycle start pulse loads the mode, the block width, the block height and the weight. Samples then arrive eight lanes per beat under a valid/ready handshake: plane A, plane B and one mask byte per lane. Each accepted beat yields one registered output beat of eight pixels. The output beat also carries its column, its row and an end-of-block flag. When the block is four pixels wide, one beat holds two rows.

Top module: `pred_blend`

## Requirements
- R1: Mode 0 (average): each pixel is (a + b + 16) >> 5, computed on the 16-bit wrapped sum, then clamped.
- R2: Mode 1 (weighted): each pixel is (a*w + b*(16 - w) + 128) >> 8, for a weight w from 0 to 16 inclusive.
- R3: Mode 2 (masked): lane i uses mask byte i, held in bits [8i+7:8i]. Each pixel is (a*m + b*(64 - m) + 512) >> 10.
- R4: Every result is clamped to an unsigned 8-bit value. Negative results give 0 and results above 255 give 255. Lane i of a sample bus is held in bits [16i+15:16i], and lane i of the pixel bus in bits [8i+7:8i].
- R5: For widths of 8 and above, each row takes width/8 beats. The beats come out in raster order, with out_x = 8 × (beat within the row) and out_y = row. out_last is high only on the final beat of the block.
- R6: At width 4, each beat carries two rows. Lanes 0..3 hold row out_y and lanes 4..7 hold row out_y+1. out_x is 0, and out_y advances by 2 on each beat.
- R7: A start is rejected when any of these holds: the width is not 4, 8, 16, 32, 64 or 128; the height is 0; the height is odd at width 4; the mode is 3; or the mode is 1 and the weight is above 16. A rejected start pulses err in the next cycle, produces no output, and leaves busy low.
- R8: In mode 2, an accepted beat with any mask byte above 64 pulses err in the next cycle. That beat produces no output, and the block returns to idle. In modes 0 and 1, mask bytes are ignored.
- R9: done pulses for exactly one cycle, in the cycle after the handshake of the final output beat. busy is low in that cycle.
- R10: While out_valid is high and out_ready is low, all output fields hold their values and in_ready stays low.
- R11: After reset, out_valid, in_ready, busy, done and err are all low.
- R12: A start pulse that arrives while a block is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Single-cycle request to begin a block |
| start_mode | input | 2 | 0 average, 1 weighted, 2 masked, 3 reserved |
| start_width | input | 8 | Block width in pixels |
| start_height | input | 8 | Block height in rows |
| start_weight | input | 5 | Scalar weight for mode 1 |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high together with in_valid |
| in_a | input | 128 | Eight signed 16-bit plane A samples |
| in_b | input | 128 | Eight signed 16-bit plane B samples |
| in_mask | input | 64 | Eight mask bytes |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_pix | output | 64 | Eight 8-bit pixels |
| out_x | output | 8 | Column of lane 0 |
| out_y | output | 8 | Row of lane 0 |
| out_last | output | 1 | Final beat of the block |
| done | output | 1 | One-cycle pulse after the final beat has been taken |
| err | output | 1 | One-cycle pulse on a rejected start or a bad mask beat |
| busy | output | 1 | A block is in progress |

## Verification
The assertions check the handshake rules on every cycle. They confirm that a stalled output beat stays frozen and that input is refused while it waits. They confirm that done follows only a taken last beat and lasts one cycle, that an error pulse leaves the block idle, and that column positions stay aligned to the lane count. Only the bench scenarios can show that the pixel values are correct. Those scenarios check the pixels of each mode against the direct weighted-sum formulas, the clamping at both extremes, the row pairing at width 4, the rejection of each kind of bad start, the abort on an out-of-range mask byte, and a stray start arriving in the middle of a block.

// File: rtl/blend_pkg.sv
package blend_pkg;

    typedef enum logic [1:0] {
        MD_AVG  = 2'd0,
        MD_WAVG = 2'd1,
        MD_MASK = 2'd2,
        MD_RSVD = 2'd3
    } blend_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } seq_st_e;

    localparam int WGT_MAX  = 16;
    localparam int MASK_MAX = 64;

endpackage

// File: rtl/blend_lane.sv
module blend_lane
    import blend_pkg::*;
#(
    parameter int SAMP_W = 16,
    parameter int PIX_W  = 8,
    parameter int WGT_W  = 5,
    parameter int MSK_W  = 8
) (
    input  blend_mode_e        mode,
    input  logic [SAMP_W-1:0]  a,
    input  logic [SAMP_W-1:0]  b,
    input  logic [WGT_W-1:0]   wgt,
    input  logic [MSK_W-1:0]   msk,
    output logic [PIX_W-1:0]   pix
);
    localparam int RW  = 2*SAMP_W + 8;
    localparam int FSH = $clog2(WGT_MAX);
    localparam int ASH = FSH + 1;
    localparam int WSH = SAMP_W - $clog2(WGT_MAX);
    localparam int MSH = SAMP_W - $clog2(MASK_MAX);
    localparam logic signed [RW-1:0] AVG_RND = RW'(1) <<< (ASH-1);
    localparam logic signed [RW-1:0] BLD_RND = RW'(1) <<< (FSH-1);
    localparam logic signed [RW-1:0] PMAX    = RW'((1 << PIX_W) - 1);

    logic signed [SAMP_W-1:0] sa, sb, ssum;
    logic signed [RW-1:0]     wa, wb, wsum, dif, coef, prod, hi, val;
    logic [RW-1:0]            mag;

    always_comb begin
        sa   = signed'(a);
        sb   = signed'(b);
        ssum = sa + sb;
        wa   = RW'(sa);
        wb   = RW'(sb);
        wsum = RW'(ssum);
        // scale the weight or mask so the high half of the product is the blend term
        mag  = (mode == MD_WAVG) ? (RW'(wgt) << WSH) : (RW'(msk) << MSH);
        coef = -signed'(mag);
        dif  = wb - wa;
        prod = dif * coef;
        hi   = prod >>> SAMP_W;
        if (mode == MD_AVG) begin
            val = (wsum + AVG_RND) >>> ASH;
        end else begin
            val = (hi + wb + BLD_RND) >>> FSH;
        end
        if (val < 0) begin
            pix = '0;
        end else if (val > PMAX) begin
            pix = '1;
        end else begin
            pix = val[PIX_W-1:0];
        end
    end
endmodule

// File: rtl/blend_cfg_chk.sv
module blend_cfg_chk
    import blend_pkg::*;
#(
    parameter int DIM_W = 8,
    parameter int WGT_W = 5,
    parameter int LANES = 8
) (
    input  blend_mode_e       mode,
    input  logic [DIM_W-1:0]  width,
    input  logic [DIM_W-1:0]  height,
    input  logic [WGT_W-1:0]  wgt,
    output logic              ok,
    output logic              narrow
);
    localparam int MIN_WID = LANES / 2;
    localparam int MAX_WID = LANES * 16;

    logic width_ok, height_ok, mode_ok;

    always_comb begin
        width_ok  = $onehot(width) && (width >= DIM_W'(MIN_WID)) && (width <= DIM_W'(MAX_WID));
        narrow    = (width == DIM_W'(MIN_WID));
        height_ok = (height != '0) && !(narrow && height[0]);
        mode_ok   = (mode != MD_RSVD) && !((mode == MD_WAVG) && (wgt > WGT_W'(WGT_MAX)));
        ok        = width_ok && height_ok && mode_ok;
    end
endmodule

// File: rtl/pred_blend.sv
module pred_blend
    import blend_pkg::*;
#(
    parameter int LANES  = 8,
    parameter int SAMP_W = 16,
    parameter int PIX_W  = 8,
    parameter int DIM_W  = 8,
    parameter int WGT_W  = 5,
    parameter int MSK_W  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [1:0]               start_mode,
    input  logic [DIM_W-1:0]         start_width,
    input  logic [DIM_W-1:0]         start_height,
    input  logic [WGT_W-1:0]         start_weight,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [LANES*SAMP_W-1:0]  in_a,
    input  logic [LANES*SAMP_W-1:0]  in_b,
    input  logic [LANES*MSK_W-1:0]   in_mask,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic [LANES*PIX_W-1:0]   out_pix,
    output logic [DIM_W-1:0]         out_x,
    output logic [DIM_W-1:0]         out_y,
    output logic                     out_last,
    output logic                     done,
    output logic                     err,
    output logic                     busy
);
    localparam int XSH = $clog2(LANES);

    typedef struct packed {
        seq_st_e                st;
        blend_mode_e            mode;
        logic [WGT_W-1:0]       wgt;
        logic                   narrow;
        logic [DIM_W-1:0]       cols;
        logic [DIM_W-1:0]       hgt;
        logic [DIM_W-1:0]       col;
        logic [DIM_W:0]         row;
        logic                   ov;
        logic [LANES*PIX_W-1:0] pix;
        logic [DIM_W-1:0]       ox;
        logic [DIM_W-1:0]       oy;
        logic                   olast;
        logic                   done;
        logic                   err;
    } state_t;

    state_t d, q;

    blend_mode_e            st_mode;
    logic                   cfg_ok, cfg_narrow;
    logic [LANES*PIX_W-1:0] lane_pix;
    logic [LANES-1:0]       lane_bad;
    logic                   in_fire, out_fire, last_col, last_beat, mask_bad;
    logic [DIM_W:0]         row_nx;

    assign st_mode = blend_mode_e'(start_mode);

    blend_cfg_chk #(
        .DIM_W (DIM_W),
        .WGT_W (WGT_W),
        .LANES (LANES)
    ) u_cfg (
        .mode   (st_mode),
        .width  (start_width),
        .height (start_height),
        .wgt    (start_weight),
        .ok     (cfg_ok),
        .narrow (cfg_narrow)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        blend_lane #(
            .SAMP_W (SAMP_W),
            .PIX_W  (PIX_W),
            .WGT_W  (WGT_W),
            .MSK_W  (MSK_W)
        ) u_lane (
            .mode (q.mode),
            .a    (in_a[i*SAMP_W +: SAMP_W]),
            .b    (in_b[i*SAMP_W +: SAMP_W]),
            .wgt  (q.wgt),
            .msk  (in_mask[i*MSK_W +: MSK_W]),
            .pix  (lane_pix[i*PIX_W +: PIX_W])
        );
        assign lane_bad[i] = in_mask[i*MSK_W +: MSK_W] > MSK_W'(MASK_MAX);
    end

    assign in_ready = (q.st == ST_RUN) && (!q.ov || out_ready);

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        d.err     = 1'b0;
        in_fire   = in_valid && in_ready;
        out_fire  = q.ov && out_ready;
        last_col  = (q.col == q.cols - DIM_W'(1));
        row_nx    = q.row + (q.narrow ? (DIM_W+1)'(2) : (DIM_W+1)'(1));
        last_beat = last_col && (row_nx >= {1'b0, q.hgt});
        mask_bad  = (q.mode == MD_MASK) && (|lane_bad);

        if (out_fire) begin
            d.ov = 1'b0;
        end

        unique case (q.st)
            ST_IDLE: begin
                if (start && !q.ov) begin
                    if (!cfg_ok) begin
                        d.err = 1'b1;
                    end else begin
                        d.st     = ST_RUN;
                        d.mode   = st_mode;
                        d.wgt    = start_weight;
                        d.narrow = cfg_narrow;
                        d.cols   = cfg_narrow ? DIM_W'(1) : (start_width >> XSH);
                        d.hgt    = start_height;
                        d.col    = '0;
                        d.row    = '0;
                    end
                end
            end
            ST_RUN: begin
                if (in_fire) begin
                    if (mask_bad) begin
                        d.err = 1'b1;
                        d.st  = ST_IDLE;
                    end else begin
                        d.ov    = 1'b1;
                        d.pix   = lane_pix;
                        d.ox    = q.narrow ? '0 : DIM_W'(q.col << XSH);
                        d.oy    = q.row[DIM_W-1:0];
                        d.olast = last_beat;
                        if (last_col) begin
                            d.col = '0;
                            d.row = row_nx;
                        end else begin
                            d.col = q.col + DIM_W'(1);
                        end
                        if (last_beat) begin
                            d.st = ST_DRAIN;
                        end
                    end
                end
            end
            ST_DRAIN: begin
                if (out_fire) begin
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign out_valid = q.ov;
    assign out_pix   = q.pix;
    assign out_x     = q.ox;
    assign out_y     = q.oy;
    assign out_last  = q.olast;
    assign done      = q.done;
    assign err       = q.err;
    assign busy      = (q.st != ST_IDLE);
endmodule

// File: rtl/pred_blend_chk.sv
module pred_blend_chk #(
    parameter int LANES = 8,
    parameter int PIX_W = 8,
    parameter int DIM_W = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_ready,
    input logic                   out_valid,
    input logic                   out_ready,
    input logic [LANES*PIX_W-1:0] out_pix,
    input logic [DIM_W-1:0]       out_x,
    input logic [DIM_W-1:0]       out_y,
    input logic                   out_last,
    input logic                   done,
    input logic                   err,
    input logic                   busy
);
    localparam int XSH = $clog2(LANES);

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_pix) && $stable(out_x)
                                    && $stable(out_y) && $stable(out_last));

    p_no_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready);

    p_last_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_last |=> done && !busy);

    p_done_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(out_valid && out_ready && out_last));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // covers both the rejected start (R7) and the mask abort (R8)
    p_err_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !busy && !in_ready);

    p_ready_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> busy);

    p_col_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_x[XSH-1:0] == '0);
endmodule

bind pred_blend pred_blend_chk #(
    .LANES (LANES),
    .PIX_W (PIX_W),
    .DIM_W (DIM_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_pix   (out_pix),
    .out_x     (out_x),
    .out_y     (out_y),
    .out_last  (out_last),
    .done      (done),
    .err       (err),
    .busy      (busy)
);

// File: tb/pred_blend_tb.sv
module pred_blend_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [1:0]   start_mode = '0;
    logic [7:0]   start_width = '0;
    logic [7:0]   start_height = '0;
    logic [4:0]   start_weight = '0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [127:0] in_a = '0;
    logic [127:0] in_b = '0;
    logic [63:0]  in_mask = '0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [63:0]  out_pix;
    logic [7:0]   out_x, out_y;
    logic         out_last, done, err, busy;

    int n_chk = 0;
    int n_fail = 0;

    logic [127:0] ta [256];
    logic [127:0] tb_s [256];
    logic [63:0]  tm [256];

    always #10 clk = ~clk;

    pred_blend u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_mode(start_mode),
        .start_width(start_width), .start_height(start_height), .start_weight(start_weight),
        .in_valid(in_valid), .in_ready(in_ready), .in_a(in_a), .in_b(in_b), .in_mask(in_mask),
        .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix), .out_x(out_x),
        .out_y(out_y), .out_last(out_last), .done(done), .err(err), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_beat(input int mode, input int w,
            input logic [127:0] a, input logic [127:0] b, input logic [63:0] m);
        logic [63:0] r;
        for (int i = 0; i < 8; i++) begin
            int x, y, k, v;
            x = $signed(a[16*i +: 16]);
            y = $signed(b[16*i +: 16]);
            k = m[8*i +: 8];
            if (mode == 0)      v = (x + y + 16) >>> 5;
            else if (mode == 1) v = (x * w + y * (16 - w) + 128) >>> 8;
            else                v = (x * k + y * (64 - k) + 512) >>> 10;
            if (v < 0) v = 0;
            if (v > 255) v = 255;
            r[8*i +: 8] = v[7:0];
        end
        return r;
    endfunction

    function automatic logic [15:0] pick(input int pat);
        int v;
        if (pat == 1) begin
            case ($urandom_range(0, 2))
                0: v = -16000;
                1: v = 16000;
                default: v = $urandom_range(0, 32000) - 16000;
            endcase
        end else begin
            v = $urandom_range(0, 12000) - 3000;
        end
        return v[15:0];
    endfunction

    task automatic pulse_start(input int mode, input int w, input int h, input int wgt);
        @(negedge clk);
        start = 1'b1; start_mode = mode[1:0]; start_width = w[7:0];
        start_height = h[7:0]; start_weight = wgt[4:0];
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_block(input int mode, input int w, input int h, input int wgt,
                             input int pat, input int rdy, input int abort_at, input bit ign);
        int nb, cols, ib, ob, cyc;
        bit fin, hold, exp_err, exp_done;
        logic [63:0] hp;
        logic [7:0] hx, hy;
        logic hl;
        string tag;
        tag = (pat == 1) ? "R4" : (mode == 0) ? "R1" : (mode == 1) ? "R2" : "R3";
        nb = (w == 4) ? h / 2 : (w / 8) * h;
        cols = (w == 4) ? 1 : w / 8;
        for (int k = 0; k < nb; k++) begin
            for (int i = 0; i < 8; i++) begin
                ta[k][16*i +: 16] = pick(pat);
                tb_s[k][16*i +: 16] = pick(pat);
                if (mode == 2) begin
                    int mv;
                    mv = ($urandom_range(0, 4) == 0) ? 64 * $urandom_range(0, 1) : $urandom_range(0, 64);
                    tm[k][8*i +: 8] = mv[7:0];
                end else begin
                    tm[k][8*i +: 8] = 8'($urandom_range(0, 255));
                end
            end
        end
        if (abort_at >= 0) tm[abort_at][8*5 +: 8] = 8'd65;
        pulse_start(mode, w, h, wgt);
        ib = 0; ob = 0; cyc = 0; fin = 0; hold = 0; exp_err = 0; exp_done = 0;
        hp = '0; hx = '0; hy = '0; hl = 1'b0;
        while (!fin) begin
            out_ready = ($urandom_range(0, 99) < rdy);
            if (ib < nb && !exp_err && !exp_done) begin
                in_valid = ($urandom_range(0, 9) < 8);
                in_a = ta[ib]; in_b = tb_s[ib]; in_mask = tm[ib];
            end else begin
                in_valid = 1'b0;
            end
            start = ign && (cyc == 3);
            if (start) begin
                start_mode = 2'd0; start_width = 8'd4; start_height = 8'd2;
            end
            #1;
            if (hold)
                chk(out_valid && out_pix == hp && out_x == hx && out_y == hy && out_last == hl,
                    "R10", "held beat", out_pix, hp);
            if (exp_err) begin
                chk(err && !busy && !out_valid && ob == abort_at, "R8", "mask abort",
                    {err, busy, out_valid}, 3'b100);
                fin = 1;
            end else if (exp_done) begin
                chk(done && !busy, "R9", "done pulse", {done, busy}, 2'b10);
                fin = 1;
            end else begin
                hold = out_valid && !out_ready;
                if (hold) begin
                    chk(!in_ready, "R10", "in_ready while stalled", in_ready, 0);
                    hp = out_pix; hx = out_x; hy = out_y; hl = out_last;
                end
                if (out_valid && out_ready) begin
                    if (ob >= nb) begin
                        chk(0, "R5", "extra output beat", ob, nb);
                    end else begin
                        int ex, ey;
                        ex = (w == 4) ? 0 : (ob % cols) * 8;
                        ey = (w == 4) ? 2 * ob : ob / cols;
                        chk(out_pix == ref_beat(mode, wgt, ta[ob], tb_s[ob], tm[ob]),
                            tag, "pixels", out_pix, ref_beat(mode, wgt, ta[ob], tb_s[ob], tm[ob]));
                        chk(out_x == ex[7:0] && out_y == ey[7:0],
                            (w == 4) ? "R6" : "R5", "position", {out_x, out_y}, {ex[7:0], ey[7:0]});
                        chk(out_last == (ob == nb - 1), "R5", "last flag", out_last, (ob == nb - 1));
                        if (out_last) exp_done = 1;
                    end
                    ob++;
                end
                if (in_valid && in_ready) begin
                    if (ib == abort_at) exp_err = 1;
                    ib++;
                end
            end
            @(negedge clk);
            start = 1'b0;
            cyc++;
            if (cyc > 4000) begin
                chk(0, tag, "block never finished", ob, nb);
                fin = 1;
            end
        end
        in_valid = 1'b0;
        out_ready = 1'b0;
    endtask

    task automatic bad_start(input int mode, input int w, input int h, input int wgt);
        pulse_start(mode, w, h, wgt);
        chk(err && !busy, "R7", "err after rejected start", {err, busy}, 2'b10);
        @(negedge clk);
        chk(!err && !busy && !out_valid, "R7", "quiet after rejection",
            {err, busy, out_valid}, 3'b000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "R9", "watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        chk(!out_valid && !in_ready && !busy && !done && !err, "R11", "reset state",
            {out_valid, in_ready, busy, done, err}, 5'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid && !in_ready && !busy, "R11", "idle after reset",
            {out_valid, in_ready, busy}, 3'b0);

        run_block(0, 16, 4, 0, 0, 60, -1, 0);
        run_block(0, 4, 6, 0, 0, 100, -1, 0);
        run_block(1, 8, 3, 0, 0, 100, -1, 0);
        run_block(1, 32, 2, 16, 0, 70, -1, 0);
        run_block(1, 64, 2, 7, 0, 50, -1, 0);
        run_block(2, 128, 2, 0, 0, 70, -1, 0);
        run_block(2, 4, 4, 0, 0, 100, -1, 0);
        run_block(2, 32, 4, 0, 0, 40, -1, 0);
        run_block(0, 8, 2, 0, 1, 100, -1, 0);
        run_block(1, 16, 2, 5, 1, 80, -1, 0);
        run_block(2, 8, 2, 0, 1, 100, -1, 0);
        // R12: stray start in the middle of a block
        run_block(2, 16, 4, 0, 0, 50, -1, 1);
        // R8: out-of-range mask byte in beat 2
        run_block(2, 16, 2, 0, 0, 100, 2, 0);

        bad_start(0, 12, 2, 0);
        bad_start(0, 2, 2, 0);
        bad_start(0, 8, 0, 0);
        bad_start(2, 4, 3, 0);
        bad_start(1, 8, 2, 17);
        bad_start(3, 8, 2, 0);

        run_block(0, 8, 1, 0, 0, 100, -1, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule